// File: doc/BRIEF.md
# Cycle Utilisation Counter Bank

This block holds a bank of 31-bit cycle counters that software reaches through a simple register port (address, write data, write enable, read enable, read data). Each counter has its own control, source-mask and threshold registers. The control field picks what the counter does on each clock. It can count every cycle, which gives a reference count of elapsed time. It can count only the cycles in which at least one of the busy-source inputs picked by its mask is high, which gives a utilisation count. It can also hold its value. An optional filter makes a busy cycle count only if the masked sources were also active in the cycle before.

A counter stops at its threshold and does not wrap. When counter 0, the reference counter, reaches its threshold, a sticky interrupt-status bit is set and drives the `irq_o` output. This happens only when the interrupt-configuration bit is 0. Software clears the status bit by writing a 1 to it. Software usually runs counter 0 in always mode and another counter in busy mode. It then reads both counts, works out the ratio, and clears both counters by writing bit 31 of their count registers.

Top module: `perf_cnt_bank`

## Requirements
- R1: After reset every count is 0, every control and mask register is 0, every threshold is 0x7FFFFFFF, and both the interrupt-configuration bit and the status bit are 0.
- R2: The register map is as follows. Counter n has its count at byte address 16n, its control at 16n+4 and its mask at 16n+8. Its threshold is at 0x200+4n. The interrupt configuration is at 0x300 and the status at 0x304. Read data appears on `rdata_o` one clock after `re_i`. Control reads return bits [2:0] only. Any other address reads 0.
- R3: With control bits [1:0] = 3 the counter increments on every clock.
- R4: With control bits [1:0] = 2 the counter increments only on clocks where `busy_i` AND the counter's mask is non-zero.
- R5: Control bit 2 = 1 enables the filter. A busy-mode cycle then counts only if the masked busy sources were non-zero on that clock and on the one before. With bit 2 = 0 no filtering takes place.
- R6: Control bits [1:0] = 0 or 1 hold the counter at its value.
- R7: A write to a count register with bit 31 set clears that counter. A write with bit 31 clear has no effect. Counts and thresholds read back as 31-bit values with bit 31 = 0.
- R8: A clearing write takes priority over an increment on the same clock, so the counter reads 0 after that clock.
- R9: A counter increments only while its count is below its threshold. It stops at the threshold, and it stays where it is if the threshold is lowered below the count.
- R10: When counter 0 steps onto its threshold and configuration bit 0 is 0, status bit 0 is set and `irq_o` follows it. With configuration bit 0 = 1 the status bit is not set.
- R11: Writing 1 to status bit 0 clears it and writing 0 leaves it as it is. When a clear and a threshold hit fall on the same clock, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Read data, valid the clock after re_i |
| busy_i | input | SRC_W | Busy-source vector, one bit per engine |
| irq_o | output | 1 | Threshold-hit status of counter 0 |

## Verification
The assertions assume that reset is held high from time zero and that `busy_i`, `we_i` and `addr_i` change only between rising edges, synchronous to `clk`. They also assume that a write to the count registers is the only path that can bring a count back to zero. The stimulus drives every input on the falling edge, keeps all addresses word-aligned and never raises read and write in the same cycle. It brackets each counting window with control writes, so the number of counted clocks is known exactly.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 31;

    // register map anchors (byte addresses)
    localparam int SLOT_SHIFT    = 4;
    localparam int THR_BASE      = 32'h200;
    localparam int IRQ_CFG_ADDR  = 32'h300;
    localparam int IRQ_STAT_ADDR = 32'h304;

    typedef enum logic [1:0] {
        MODE_HOLD_A = 2'd0,
        MODE_HOLD_B = 2'd1,
        MODE_BUSY   = 2'd2,
        MODE_ALL    = 2'd3
    } cnt_mode_e;

    typedef struct packed {
        logic      filt_en;
        cnt_mode_e mode;
    } cnt_ctrl_t;

    typedef enum logic [1:0] {
        SUB_COUNT = 2'd0,
        SUB_CTRL  = 2'd1,
        SUB_MASK  = 2'd2,
        SUB_NONE  = 2'd3
    } cnt_sub_e;

    function automatic logic step_wanted(cnt_mode_e m, logic act);
        return (m == MODE_ALL) || ((m == MODE_BUSY) && act);
    endfunction

endpackage

// File: rtl/perf_cnt_dec.sv
module perf_cnt_dec
    import perf_cnt_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int ADDR_W  = 12,
    parameter int IDX_W   = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              in_slot_o,
    output logic              in_thr_o,
    output logic              is_cfg_o,
    output logic              is_stat_o,
    output logic [IDX_W-1:0]  idx_o,
    output cnt_sub_e          sub_o
);

    localparam logic [ADDR_W-1:0] SLOT_END_A = ADDR_W'(NUM_CNT << SLOT_SHIFT);
    localparam logic [ADDR_W-1:0] THR_BASE_A = ADDR_W'(THR_BASE);
    localparam logic [ADDR_W-1:0] THR_END_A  = ADDR_W'(THR_BASE + NUM_CNT * 4);
    localparam logic [ADDR_W-1:0] CFG_A      = ADDR_W'(IRQ_CFG_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A     = ADDR_W'(IRQ_STAT_ADDR);

    logic aligned;

    always_comb begin
        aligned   = (addr_i[1:0] == 2'b00);
        sub_o     = cnt_sub_e'(addr_i[3:2]);
        in_slot_o = aligned && (addr_i < SLOT_END_A) && (sub_o != SUB_NONE);
        in_thr_o  = aligned && (addr_i >= THR_BASE_A) && (addr_i < THR_END_A);
        is_cfg_o  = (addr_i == CFG_A);
        is_stat_o = (addr_i == STAT_A);
        idx_o     = in_thr_o ? addr_i[2 +: IDX_W] : addr_i[SLOT_SHIFT +: IDX_W];
    end

endmodule

// File: rtl/perf_cnt_slice.sv
module perf_cnt_slice
    import perf_cnt_pkg::*;
#(
    parameter int SRC_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  busy_i,
    input  logic              clr_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_mask_i,
    input  logic              wr_thr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  thr_o,
    output logic [SRC_W-1:0]  mask_o,
    output cnt_ctrl_t         ctrl_o,
    output logic              hit_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr_q;
    logic [SRC_W-1:0] mask_q;
    cnt_ctrl_t        ctrl_q;
    logic             act_q;

    logic act_now;
    logic act;
    logic room;
    logic step;

    always_comb begin
        act_now = |(busy_i & mask_q);
        act     = ctrl_q.filt_en ? (act_now && act_q) : act_now;
        room    = (cnt_q < thr_q);
        step    = step_wanted(ctrl_q.mode, act) && room;
        hit_o   = step && !clr_i && ((cnt_q + CNT_W'(1)) == thr_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            thr_q  <= '1;
            mask_q <= '0;
            ctrl_q <= '0;
            act_q  <= 1'b0;
        end else begin
            act_q <= act_now;
            if (clr_i) begin
                cnt_q <= '0;
            end else if (step) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (wr_thr_i) begin
                thr_q <= wdata_i[CNT_W-1:0];
            end
            if (wr_mask_i) begin
                mask_q <= wdata_i[SRC_W-1:0];
            end
            if (wr_ctrl_i) begin
                ctrl_q <= cnt_ctrl_t'(wdata_i[2:0]);
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign thr_o  = thr_q;
    assign mask_o = mask_q;
    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/perf_cnt_irq.sv
module perf_cnt_irq (
    input  logic clk,
    input  logic rst,
    input  logic hit_i,
    input  logic mute_i,
    input  logic clr_i,
    output logic stat_o
);

    logic stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= 1'b0;
        end else if (hit_i && !mute_i) begin
            stat_q <= 1'b1;
        end else if (clr_i) begin
            stat_q <= 1'b0;
        end
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/perf_cnt_bank.sv
module perf_cnt_bank
    import perf_cnt_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int SRC_W   = 32,
    parameter int ADDR_W  = 12,
    parameter int IRQ_SRC = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic              we_i,
    input  logic              re_i,
    output logic [31:0]       rdata_o,
    input  logic [SRC_W-1:0]  busy_i,
    output logic              irq_o
);

    localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
    localparam logic [NUM_CNT-1:0] IRQ_SEL = NUM_CNT'(1) << IRQ_SRC;

    logic             in_slot;
    logic             in_thr;
    logic             is_cfg;
    logic             is_stat;
    logic [IDX_W-1:0] idx;
    cnt_sub_e         sub;

    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_CNT-1:0][CNT_W-1:0] thr_all;
    logic [NUM_CNT-1:0][SRC_W-1:0] mask_all;
    logic [NUM_CNT-1:0][1:0]       mode_all;
    cnt_ctrl_t                     ctrl_all [NUM_CNT];
    logic [NUM_CNT-1:0]            clr_all;
    logic [NUM_CNT-1:0]            hit_all;

    logic        hit_irq;
    logic        stat_clr;
    logic        irq_cfg_q;
    logic [31:0] rd_val;
    logic [31:0] mask_ext;

    perf_cnt_dec #(
        .NUM_CNT(NUM_CNT),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_dec (
        .addr_i   (addr_i),
        .in_slot_o(in_slot),
        .in_thr_o (in_thr),
        .is_cfg_o (is_cfg),
        .is_stat_o(is_stat),
        .idx_o    (idx),
        .sub_o    (sub)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_slot
        logic sel_slot;
        logic sel_thr;

        assign sel_slot   = we_i && in_slot && (idx == IDX_W'(g));
        assign sel_thr    = we_i && in_thr && (idx == IDX_W'(g));
        assign clr_all[g] = sel_slot && (sub == SUB_COUNT) && wdata_i[31];

        perf_cnt_slice #(
            .SRC_W(SRC_W)
        ) u_slice (
            .clk      (clk),
            .rst      (rst),
            .busy_i   (busy_i),
            .clr_i    (clr_all[g]),
            .wr_ctrl_i(sel_slot && (sub == SUB_CTRL)),
            .wr_mask_i(sel_slot && (sub == SUB_MASK)),
            .wr_thr_i (sel_thr),
            .wdata_i  (wdata_i),
            .cnt_o    (cnt_all[g]),
            .thr_o    (thr_all[g]),
            .mask_o   (mask_all[g]),
            .ctrl_o   (ctrl_all[g]),
            .hit_o    (hit_all[g])
        );

        assign mode_all[g] = ctrl_all[g].mode;
    end

    assign hit_irq  = |(hit_all & IRQ_SEL);
    assign stat_clr = we_i && is_stat && wdata_i[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_cfg_q <= 1'b0;
        end else if (we_i && is_cfg) begin
            irq_cfg_q <= wdata_i[0];
        end
    end

    perf_cnt_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .hit_i (hit_irq),
        .mute_i(irq_cfg_q),
        .clr_i (stat_clr),
        .stat_o(irq_o)
    );

    always_comb begin
        mask_ext = '0;
        mask_ext[SRC_W-1:0] = mask_all[idx];
        rd_val = '0;
        if (in_slot) begin
            case (sub)
                SUB_COUNT: rd_val = {1'b0, cnt_all[idx]};
                SUB_CTRL:  rd_val = {29'b0, ctrl_all[idx]};
                SUB_MASK:  rd_val = mask_ext;
                default:   rd_val = '0;
            endcase
        end else if (in_thr) begin
            rd_val = {1'b0, thr_all[idx]};
        end else if (is_cfg) begin
            rd_val = {31'b0, irq_cfg_q};
        end else if (is_stat) begin
            rd_val = {31'b0, irq_o};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
        end else if (re_i) begin
            rdata_o <= rd_val;
        end
    end

endmodule

// File: rtl/perf_cnt_bank_chk.sv
module perf_cnt_bank_chk #(
    parameter int NUM_CNT = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     irq_o,
    input logic                     irq_cfg,
    input logic                     stat_clr,
    input logic                     hit_irq,
    input logic [NUM_CNT-1:0][30:0] cnt_all,
    input logic [NUM_CNT-1:0][30:0] thr_all,
    input logic [NUM_CNT-1:0]       clr_all,
    input logic [NUM_CNT-1:0][1:0]  mode_all
);

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        assert_step_R3: assert property (@(posedge clk) disable iff (rst)
            (cnt_all[g] == $past(cnt_all[g])) ||
            (cnt_all[g] == $past(cnt_all[g]) + 31'd1) ||
            (cnt_all[g] == 31'd0));

        assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
            (!mode_all[g][1] && !clr_all[g]) |=> (cnt_all[g] == $past(cnt_all[g])));

        assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
            clr_all[g] |=> (cnt_all[g] == 31'd0));

        assert_sat_R9: assert property (@(posedge clk) disable iff (rst)
            ((cnt_all[g] >= thr_all[g]) && !clr_all[g]) |=> (cnt_all[g] == $past(cnt_all[g])));
    end

    assert_irq_set_R10: assert property (@(posedge clk) disable iff (rst)
        (hit_irq && !irq_cfg) |=> irq_o);

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(hit_irq && !irq_cfg));

    assert_irq_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && !(hit_irq && !irq_cfg)) |=> !irq_o);

endmodule

bind perf_cnt_bank perf_cnt_bank_chk #(
    .NUM_CNT(NUM_CNT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq_o   (irq_o),
    .irq_cfg (irq_cfg_q),
    .stat_clr(stat_clr),
    .hit_irq (hit_irq),
    .cnt_all (cnt_all),
    .thr_all (thr_all),
    .clr_all (clr_all),
    .mode_all(mode_all)
);

// File: tb/tb_perf_cnt_bank.sv
module tb_perf_cnt_bank;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int SRC_W      = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic              we = 1'b0;
    logic              re = 1'b0;
    logic [SRC_W-1:0]  busy = '0;
    logic [31:0]       rdata;
    logic              irq;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_pend = 1'b0;

    perf_cnt_bank #(
        .NUM_CNT(8),
        .SRC_W  (SRC_W),
        .ADDR_W (ADDR_W)
    ) dut (
        .clk    (clk),
        .rst    (rst),
        .addr_i (addr),
        .wdata_i(wdata),
        .we_i   (we),
        .re_i   (re),
        .rdata_o(rdata),
        .busy_i (busy),
        .irq_o  (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [ADDR_W-1:0] a_cnt(int n);  return ADDR_W'(n * 16);        endfunction
    function automatic logic [ADDR_W-1:0] a_ctrl(int n); return ADDR_W'(n * 16 + 4);    endfunction
    function automatic logic [ADDR_W-1:0] a_mask(int n); return ADDR_W'(n * 16 + 8);    endfunction
    function automatic logic [ADDR_W-1:0] a_thr(int n);  return ADDR_W'(32'h200 + n * 4); endfunction
    localparam logic [ADDR_W-1:0] A_CFG  = 12'h300;
    localparam logic [ADDR_W-1:0] A_STAT = 12'h304;
    localparam logic [31:0]       CLR    = 32'h8000_0000;

    task automatic expect_eq(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when read data is due
    always @(posedge clk) rd_pend <= re;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                expect_eq("scoreboard underflow", rdata, 32'hx);
            end else begin
                expect_eq(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    // driver tasks: entered and left on a falling edge
    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
        addr = a; re = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_eq("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd(a_cnt(0), 32'h0, "R1 count0");
        rd(a_ctrl(2), 32'h0, "R1 ctrl2");
        rd(a_mask(4), 32'h0, "R1 mask4");
        rd(a_thr(7), 32'h7FFF_FFFF, "R1 thr7");
        rd(A_STAT, 32'h0, "R1 status");
        rd(A_CFG, 32'h0, "R1 irq cfg");

        // R2 map and decode
        wr(a_ctrl(3), 32'hFFFF_FFF5);
        rd(a_ctrl(3), 32'h5, "R2 ctrl3 readback");
        rd(a_ctrl(2), 32'h0, "R2 ctrl2 untouched");
        rd(12'h0FC, 32'h0, "R2 unmapped");
        rd(a_cnt(1) + 12'hC, 32'h0, "R2 hole in slot");
        wr(a_ctrl(3), 32'h0);
        wr(a_mask(4), 32'h0020_0001);
        rd(a_mask(4), 32'h0020_0001, "R2 mask4 readback");

        // R7 threshold width
        wr(a_thr(5), 32'hFFFF_FFFF);
        rd(a_thr(5), 32'h7FFF_FFFF, "R7 thr 31-bit");
        wr(a_thr(5), 32'h0000_1234);
        rd(a_thr(5), 32'h0000_1234, "R7 thr value");

        // R3 always mode: 9 idle + 1 disabling edge
        wr(a_ctrl(1), 32'h3);
        idle(9);
        wr(a_ctrl(1), 32'h0);
        rd(a_cnt(1), 32'd10, "R3 always count");
        rd(a_cnt(2), 32'd0, "R3 other counter idle");

        // R6 hold modes
        wr(a_ctrl(1), 32'h1);
        idle(5);
        wr(a_ctrl(1), 32'h0);
        idle(5);
        rd(a_cnt(1), 32'd10, "R6 hold modes");

        // R7 write without bit 31 ignored, with bit 31 clears
        wr(a_cnt(1), 32'h0000_1234);
        rd(a_cnt(1), 32'd10, "R7 plain write ignored");
        wr(a_cnt(1), CLR);
        rd(a_cnt(1), 32'd0, "R7 clear write");

        // R8 clear beats increment
        wr(a_ctrl(3), 32'h3);
        idle(4);
        wr(a_cnt(3), CLR);
        wr(a_ctrl(3), 32'h0);
        rd(a_cnt(3), 32'd1, "R8 clear priority");

        // R4 busy mode
        wr(a_ctrl(5), 32'h2);
        wr(a_ctrl(4), 32'h2);
        busy = 32'h0000_0001; idle(3);
        busy = 32'h0000_0020; idle(4);
        busy = 32'h0020_0000; idle(2);
        busy = 32'h0020_0001; idle(1);
        busy = '0;
        wr(a_ctrl(4), 32'h0);
        wr(a_ctrl(5), 32'h0);
        rd(a_cnt(4), 32'd6, "R4 masked busy count");
        rd(a_cnt(5), 32'd0, "R4 empty mask no count");

        // R5 filter
        wr(a_cnt(4), CLR);
        wr(a_ctrl(4), 32'h6);
        busy = 32'h0000_0001; idle(4);
        busy = '0;            idle(1);
        busy = 32'h0020_0000; idle(1);
        busy = '0;            idle(1);
        busy = 32'h0000_0001; idle(1);
        busy = '0;            idle(1);
        wr(a_ctrl(4), 32'h0);
        rd(a_cnt(4), 32'd3, "R5 filtered count");

        // R9 saturation
        wr(a_thr(2), 32'd10);
        wr(a_ctrl(2), 32'h3);
        idle(20);
        wr(a_ctrl(2), 32'h0);
        rd(a_cnt(2), 32'd10, "R9 stop at threshold");
        wr(a_thr(2), 32'd4);
        wr(a_ctrl(2), 32'h3);
        idle(3);
        wr(a_ctrl(2), 32'h0);
        rd(a_cnt(2), 32'd10, "R9 lowered threshold holds");

        // R10 status on counter 0 hit
        wr(a_thr(0), 32'd6);
        wr(a_ctrl(0), 32'h3);
        idle(3);
        expect_eq("R10 no irq before threshold", {31'b0, irq}, 32'h0);
        idle(3);
        expect_eq("R10 irq at threshold", {31'b0, irq}, 32'h1);
        wr(a_ctrl(0), 32'h0);
        rd(A_STAT, 32'h1, "R10 status read");
        rd(a_cnt(0), 32'd6, "R10 count at threshold");

        // R11 write-one-to-clear
        wr(A_STAT, 32'h0);
        expect_eq("R11 write 0 keeps status", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'h1);
        expect_eq("R11 write 1 clears", {31'b0, irq}, 32'h0);
        rd(A_STAT, 32'h0, "R11 status read");

        // R11 set beats clear on the same clock
        wr(a_cnt(0), CLR);
        wr(a_ctrl(0), 32'h3);
        idle(5);
        wr(A_STAT, 32'h1);
        expect_eq("R11 hit wins over clear", {31'b0, irq}, 32'h1);
        wr(a_ctrl(0), 32'h0);
        wr(A_STAT, 32'h1);

        // R10 suppression by configuration bit
        wr(A_CFG, 32'h1);
        rd(A_CFG, 32'h1, "R10 cfg readback");
        wr(a_cnt(0), CLR);
        wr(a_ctrl(0), 32'h3);
        idle(8);
        wr(a_ctrl(0), 32'h0);
        expect_eq("R10 muted hit", {31'b0, irq}, 32'h0);
        rd(a_cnt(0), 32'd6, "R10 muted count");
        wr(A_CFG, 32'h0);

        idle(3);
        expect_eq("scoreboard drained", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

endmodule